// File: doc/BRIEF.md
# Shared Parallel Port with Local-Priority Readback

This block is an 8-bit bidirectional port on the host side of a point-to-point parallel link. Each pin has a direction bit and a latched output value, both set through a small register bus. A second device on the far end of the cable drives the same eight lines through its own port. The block works out the level each line settles to and the value software sees when it reads the data register.

Lines that both ends leave as inputs float high. A low from either end pulls an input line low. A pin the host has set as an output behaves like a strong driver seen from the host side. Reading it always returns the host's own latch value, whatever the far end is doing. Software can therefore save and restore the data register reliably, even when the remote device has not yet released the lines.

Top module: `sharedbus_port`

## Requirements
- R1: An asynchronous active-low reset clears the direction register and the data latch to zero, so every pin starts as an input.
- R2: A write with `addr`=0 loads the data latch, and a write with `addr`=1 loads the direction register, on the rising clock edge. Reads are combinational: `addr`=1 returns the direction register and `addr`=0 returns the data readback.
- R3: On a pin whose direction bit is 1 (output), the data readback equals the latch bit, whatever the remote side drives.
- R4: On a pin whose direction bit is 0 (input), the data readback equals the resolved bus bit, which is the AND of every driver on the line.
- R5: A line that neither side drives low reads as 1.
- R6: A remote pin whose remote direction bit is 0 presents 1 to the bus. A remote port set to all inputs therefore leaves `bus_level` equal to the host's own drive.
- R7: `bus_level` is the AND of the host drive and the remote drive. The host drive is the latch bit on output pins and 1 on input pins. The remote drive is `remote_out` on remote outputs and 1 on remote inputs.
- R8: After the direction register is written with all ones and the latch with 0xE0, a read of the data register returns 0xE0 while the remote side drives 0x00 on all pins as outputs. In the same condition `bus_level` is 0x00.
- R9: A write to one register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 data, 1 direction |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Combinational read data |
| remote_out | input | WIDTH | Output values of the far-end port |
| remote_dir | input | WIDTH | Direction bits of the far-end port (1 = output) |
| bus_level | output | WIDTH | Resolved line levels toward the far end |

## Verification
The bench builds two copies of the block: one with the default WIDTH of 8 and one with WIDTH set to 4. The 8-bit copy covers the reset state and the all-outputs 0xE0 save-and-restore case against a remote that drives every line low. The 4-bit copy makes a full sweep possible: all 16 latch values, all 16 direction settings, and all 256 combinations of remote output and remote direction. Every mix of local output against remote input, remote low and remote high is therefore checked on every bit position.

// File: rtl/sharedbus_port_pkg.sv
package sharedbus_port_pkg;
   localparam int unsigned ADDR_W = 1;

   typedef enum logic [ADDR_W-1:0] {
      SEL_DATA = 1'b0,
      SEL_DIR  = 1'b1
   } port_sel_e;
endpackage

// File: rtl/sharedbus_port_regs.sv
module sharedbus_port_regs
   import sharedbus_port_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] latch_q,
   output logic [WIDTH-1:0] dir_q
);
   logic wr_data, wr_dir;

   always_comb begin
      wr_data = wr_en && (port_sel_e'(addr) == SEL_DATA);
      wr_dir  = wr_en && (port_sel_e'(addr) == SEL_DIR);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
      end else begin
         if (wr_data) latch_q <= wdata;
         if (wr_dir)  dir_q   <= wdata;
      end
   end
endmodule

// File: rtl/sharedbus_port_pin.sv
module sharedbus_port_pin (
   input  logic lat,
   input  logic dir,
   input  logic r_out,
   input  logic r_dir,
   output logic line,
   output logic rd
);
   logic host_drive, far_drive;

   always_comb begin
      host_drive = dir   ? lat   : 1'b1;
      far_drive  = r_dir ? r_out : 1'b1;
      line       = host_drive & far_drive;
      rd         = dir ? lat : line;
   end
endmodule

// File: rtl/sharedbus_port.sv
module sharedbus_port
   import sharedbus_port_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  rdata,
   input  logic [WIDTH-1:0]  remote_out,
   input  logic [WIDTH-1:0]  remote_dir,
   output logic [WIDTH-1:0]  bus_level
);
   if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
      $error("sharedbus_port: WIDTH must be 1..64");
   end

   logic [WIDTH-1:0] latch_q, dir_q, pin_rd;

   sharedbus_port_regs #(.WIDTH(WIDTH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .latch_q (latch_q),
      .dir_q   (dir_q)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      sharedbus_port_pin u_pin (
         .lat   (latch_q[i]),
         .dir   (dir_q[i]),
         .r_out (remote_out[i]),
         .r_dir (remote_dir[i]),
         .line  (bus_level[i]),
         .rd    (pin_rd[i])
      );
   end

   always_comb begin
      unique case (port_sel_e'(addr))
         SEL_DIR: rdata = dir_q;
         default: rdata = pin_rd;
      endcase
   end
endmodule

// File: rtl/sharedbus_port_chk.sv
module sharedbus_port_chk
   import sharedbus_port_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [WIDTH-1:0]  wdata,
   input logic [WIDTH-1:0]  rdata,
   input logic [WIDTH-1:0]  remote_out,
   input logic [WIDTH-1:0]  remote_dir,
   input logic [WIDTH-1:0]  bus_level,
   input logic [WIDTH-1:0]  latch_q,
   input logic [WIDTH-1:0]  dir_q
);
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (dir_q == '0 && latch_q == '0));

   // R2
   latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == SEL_DATA) |=> latch_q == $past(wdata));

   // R2
   dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == SEL_DIR) |=> dir_q == $past(wdata));

   // R9
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == SEL_DATA) |=> $stable(dir_q));

   // R3
   out_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == SEL_DATA) |-> (((rdata ^ latch_q) & dir_q) == '0));

   // R4
   in_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == SEL_DATA) |-> (((rdata ^ bus_level) & ~dir_q) == '0));

   // R5
   float_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((~bus_level) & ~dir_q & ~remote_dir) == '0);

   // R7
   low_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_level & dir_q & ~latch_q) | (bus_level & remote_dir & ~remote_out)) == '0);
endmodule

bind sharedbus_port sharedbus_port_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .addr       (addr),
   .wdata      (wdata),
   .rdata      (rdata),
   .remote_out (remote_out),
   .remote_dir (remote_dir),
   .bus_level  (bus_level),
   .latch_q    (latch_q),
   .dir_q      (dir_q)
);

// File: tb/sharedbus_port_bench.sv
module sharedbus_port_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // 8-bit instance
   logic       wr_en = 1'b0;
   logic [0:0] addr = 1'b0;
   logic [7:0] wdata = '0, rdata, r_out = '0, r_dir = '0, bus;

   sharedbus_port u_sharedbus_port (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .remote_out(r_out), .remote_dir(r_dir), .bus_level(bus)
   );

   // 4-bit instance for the full sweep
   logic       n_wr = 1'b0;
   logic [0:0] n_addr = 1'b0;
   logic [3:0] n_wdata = '0, n_rdata, n_rout = '0, n_rdir = '0, n_bus;

   sharedbus_port #(.WIDTH(4)) u_narrow (
      .clk(clk), .rst_n(rst_n), .wr_en(n_wr), .addr(n_addr), .wdata(n_wdata),
      .rdata(n_rdata), .remote_out(n_rout), .remote_dir(n_rdir), .bus_level(n_bus)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr8(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr4(input logic a, input logic [3:0] d);
      @(negedge clk);
      n_wr = 1'b1; n_addr = a; n_wdata = d;
      @(negedge clk);
      n_wr = 1'b0;
   endtask

   initial begin
      int cyc = 0;
      while (!done && cyc < 200000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [3:0] exp_bus, exp_rd;
      // Reset state, R1 and R5: remote all inputs, host all inputs
      repeat (3) @(negedge clk);
      addr = 1'b1; #1;
      check("R1 dir after reset", rdata, 8'h00);
      addr = 1'b0; #1;
      check("R1 data reads floating bus", rdata, 8'hFF);
      check("R5 undriven lines high", bus, 8'hFF);
      @(negedge clk);
      rst_n = 1'b1;

      // R8: all outputs, latch 0xE0, remote drives 0x00 as outputs
      wr8(1'b1, 8'hFF);
      wr8(1'b0, 8'hE0);
      r_dir = 8'hFF; r_out = 8'h00;
      addr = 1'b0; #1;
      check("R8 readback holds latch", rdata, 8'hE0);
      check("R8 bus pulled low", bus, 8'h00);
      addr = 1'b1; #1;
      check("R9 dir kept after data write", rdata, 8'hFF);

      // R6: remote all inputs presents ones
      r_dir = 8'h00; r_out = 8'h00;
      #1;
      check("R6 remote inputs leave host drive", bus, 8'hE0);

      // R4: host inputs see remote lows
      wr8(1'b1, 8'h0F);
      r_dir = 8'hF0; r_out = 8'h5A;
      addr = 1'b0; #1;
      check("R4 mixed readback", rdata, 8'h50);
      check("R7 mixed bus", bus, 8'h50);

      // Full sweep on 4-bit copy: R2 R3 R4 R5 R6 R7 R9
      for (int d = 0; d < 16; d++) begin
         for (int l = 0; l < 16; l++) begin
            wr4(1'b1, 4'(d));
            wr4(1'b0, 4'(l));
            n_addr = 1'b1; #1;
            check("R2 R9 sweep dir", {4'h0, n_rdata}, 8'(d));
            n_addr = 1'b0;
            for (int rr = 0; rr < 256; rr++) begin
               n_rdir = 4'(rr >> 4);
               n_rout = 4'(rr);
               #1;
               exp_bus = (4'(l) | ~4'(d)) & (n_rout | ~n_rdir);
               exp_rd  = (4'(d) & 4'(l)) | (~4'(d) & exp_bus);
               check("R7 sweep bus", {4'h0, n_bus}, {4'h0, exp_bus});
               check("R3 R4 sweep read", {4'h0, n_rdata}, {4'h0, exp_rd});
            end
         end
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule